// File: doc/BRIEF.md
# Eight-bit ALU with registered status flags

This block is the data-manipulating core of a small 8-bit processor. It takes a left and a right byte plus an operation code and produces an 8-bit result within the same cycle. The block combines the two bytes (add, compare, AND, OR, exclusive-OR) or transforms one of them (complement, increment, decrement, shift left, shift right, clear). For the one-operand group a select input chooses whether the left or the right byte is the source.

Beside the result, the block keeps a 5-bit status word in a register. Four of its bits are sign, carry, zero and overflow. A fixed per-operation write mask decides which of them an operation may update. An update happens only on a cycle marked valid. The fifth bit is an interrupt-enable flag. Arithmetic never touches it; a dedicated load port writes it. The sign flag holds the inverse of result bit 7. Overflow is the exclusive-OR of the carries out of bits 6 and 7.

Top module: `alu8_flagged`

## Requirements
- R1: Operation code 0 (add) returns (left + right) mod 256; carry is set when the true sum exceeds 255, and overflow is set to the XOR of the carries out of bits 6 and 7 (signed overflow).
- R2: Operation code 1 (compare) evaluates right minus left in two's complement. The result output passes the right operand through unchanged. Carry is set when right >= left unsigned, and overflow is set on a signed overflow of the subtraction.
- R3: Operation codes 2, 3 and 4 return the bitwise AND, OR and XOR of the two operands, and clear carry and overflow.
- R4: Operation codes 5 (complement), 6 (increment), 7 (decrement), 8 (shift left) and 9 (shift right) act on the left operand when the source select is 0 and on the right operand when it is 1. Shifts fill with zero. Increment sets carry when the operand was 0xFF and overflow when it was 0x7F. Decrement sets carry when the operand was non-zero and overflow when it was 0x80. Complement and the shifts clear carry and overflow.
- R5: After any operation code 0 to 9, status bit 0 (sign) equals the complement of bit 7 of the computed value (for compare: of the difference).
- R6: After any operation code 0 to 9, status bit 2 (zero) is 1 exactly when the computed value (for compare: the difference) is zero.
- R7: Operation code 10 (clear) and the unused codes 11 to 15 return zero and leave status bits 3:0 unchanged.
- R8: Status bits 3:0 change only on a clock edge where the valid input is 1.
- R9: Status bit 4 (interrupt enable) is loaded from the enable data input on a clock edge where the enable write input is 1, and holds otherwise, whatever operation runs.
- R10: A synchronous active-low reset clears all five status bits; layout is bit 0 sign, bit 1 carry, bit 2 zero, bit 3 overflow, bit 4 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation is real; allows status update |
| op_i | input | 4 | Operation code |
| src_sel_i | input | 1 | One-operand source: 0 left, 1 right |
| lhs_i | input | 8 | Left operand |
| rhs_i | input | 8 | Right operand |
| ien_we_i | input | 1 | Write strobe for interrupt-enable bit |
| ien_d_i | input | 1 | Value for interrupt-enable bit |
| result_o | output | 8 | Combinational result |
| status_o | output | 5 | Registered status word |

## Verification
On every cycle the assertions check several properties. Sign and zero must track the previous direct result. Logical ops and shifts must clear carry and overflow. Status must hold when there is no valid operation or the operation is a clear. The interrupt-enable bit must move only with its strobe. Compare must pass its right operand through. The exact carry and overflow values for add, compare, increment and decrement are shown only by the bench's scenarios. These compare each cycle against a bench model of the arithmetic. The scenarios include boundary operands 0x7F, 0x80, 0xFF and 0x00, and the left/right source choice of the one-operand group.

// File: rtl/alu8_pkg.sv
// Package: shared constants, operation codes and the per-operation flag mask.
// Assumes the status layout bit0 sign, bit1 carry, bit2 zero, bit3 overflow, bit4 IE.
package alu8_pkg;

    localparam int OP_W   = 4;
    localparam int STAT_W = 5;
    localparam int ST_SIGN  = 0;
    localparam int ST_CARRY = 1;
    localparam int ST_ZERO  = 2;
    localparam int ST_OVF   = 3;
    localparam int ST_IEN   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_CMP = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_COM = 4'd5,
        OP_INC = 4'd6,
        OP_DEC = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9,
        OP_CLR = 4'd10
    } alu_op_e;

    // Four arithmetic flags, packed so that bit n matches status bit n.
    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
        logic sign;
    } flags_t;

    // Which flags an operation is allowed to write.
    function automatic flags_t flag_mask(input logic [OP_W-1:0] op);
        flags_t m;
        case (op)
            OP_ADD, OP_CMP, OP_INC, OP_DEC,
            OP_AND, OP_OR, OP_XOR,
            OP_COM, OP_SHL, OP_SHR: m = '{ovf: 1'b1, zero: 1'b1, carry: 1'b1, sign: 1'b1};
            default:                m = '0;
        endcase
        return m;
    endfunction

    // True for operations whose value is produced by the adder.
    function automatic logic uses_adder(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_CMP) || (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_ripple_adder.sv
// Module: ripple-carry adder exposing the carries out of the two top bits.
// Assumes WIDTH >= 2 so that a carry out of bit WIDTH-2 exists.
module alu8_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_top_o,
    output logic             c_sub_o
);

    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    // One full adder per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ carry[i];
        assign carry[i + 1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end

    assign c_top_o = carry[WIDTH];
    assign c_sub_o = carry[WIDTH-1];

endmodule

// File: rtl/alu8_bitops.sv
// Module: non-arithmetic datapath (logic, complement, shifts, clear).
// Assumes op codes from alu8_pkg; any code it does not handle yields zero.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] res_o
);

    // Select the bitwise or shift result for the current code.
    always_comb begin
        case (op_i)
            OP_AND:  res_o = lhs_i & rhs_i;
            OP_OR:   res_o = lhs_i | rhs_i;
            OP_XOR:  res_o = lhs_i ^ rhs_i;
            OP_COM:  res_o = ~src_i;
            OP_SHL:  res_o = {src_i[WIDTH-2:0], 1'b0};
            OP_SHR:  res_o = {1'b0, src_i[WIDTH-1:1]};
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu8_status_reg.sv
// Module: five-bit status register with per-flag write enables and a
// separate load path for the interrupt-enable bit. Synchronous active-low reset.
module alu8_status_reg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  flags_t            wr_mask_i,
    input  flags_t            flags_i,
    input  logic              ien_we_i,
    input  logic              ien_d_i,
    output logic [STAT_W-1:0] status_o
);

    flags_t flags_q;
    logic   ien_q;

    // Write each arithmetic flag only where its mask bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_i & wr_mask_i) | (flags_q & ~wr_mask_i);
        end
    end

    // Interrupt-enable bit follows its own strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_we_i) begin
            ien_q <= ien_d_i;
        end
    end

    assign status_o = {ien_q, flags_q};

endmodule

// File: rtl/alu8_flagged.sv
// Module: top of the 8-bit ALU. Routes operands to the adder or the bit
// datapath, derives sign/carry/zero/overflow and hands them to the status
// register with the operation's mask. Result is combinational; status is
// registered. Assumes DATA_W >= 2.
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              src_sel_i,
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    input  logic              ien_we_i,
    input  logic              ien_d_i,
    output logic [DATA_W-1:0] result_o,
    output logic [STAT_W-1:0] status_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              c_top;
    logic              c_sub;
    logic [DATA_W-1:0] bit_res;
    logic              arith;
    logic [DATA_W-1:0] flag_val;
    flags_t            flags_new;
    flags_t            wr_mask;

    assign src   = src_sel_i ? rhs_i : lhs_i;
    assign arith = uses_adder(op_i);

    // Choose adder inputs: add, reverse subtract, +1 or -1.
    always_comb begin
        case (op_i)
            OP_ADD: begin add_a = lhs_i; add_b = rhs_i;  add_cin = 1'b0; end
            OP_CMP: begin add_a = rhs_i; add_b = ~lhs_i; add_cin = 1'b1; end
            OP_INC: begin add_a = src;   add_b = '0;     add_cin = 1'b1; end
            OP_DEC: begin add_a = src;   add_b = '1;     add_cin = 1'b0; end
            default: begin add_a = '0;   add_b = '0;     add_cin = 1'b0; end
        endcase
    end

    alu8_ripple_adder #(.WIDTH(DATA_W)) u_adder (
        .a_i     (add_a),
        .b_i     (add_b),
        .cin_i   (add_cin),
        .sum_o   (add_sum),
        .c_top_o (c_top),
        .c_sub_o (c_sub)
    );

    alu8_bitops #(.WIDTH(DATA_W)) u_bitops (
        .op_i  (op_i),
        .lhs_i (lhs_i),
        .rhs_i (rhs_i),
        .src_i (src),
        .res_o (bit_res)
    );

    // Value the flags describe; compare uses the difference.
    assign flag_val = arith ? add_sum : bit_res;

    // Drive the result; compare leaves the destination operand untouched.
    always_comb begin
        if (op_i == OP_CMP) begin
            result_o = rhs_i;
        end else begin
            result_o = flag_val;
        end
    end

    // Derive the four arithmetic flags from the computed value.
    always_comb begin
        flags_new.sign  = ~flag_val[MSB];
        flags_new.zero  = (flag_val == '0);
        flags_new.carry = arith & c_top;
        flags_new.ovf   = arith & (c_top ^ c_sub);
    end

    assign wr_mask = valid_i ? flag_mask(op_i) : flags_t'('0);

    alu8_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (wr_mask),
        .flags_i   (flags_new),
        .ien_we_i  (ien_we_i),
        .ien_d_i   (ien_d_i),
        .status_o  (status_o)
    );

endmodule

// File: rtl/alu8_flagged_chk.sv
// Checker: cycle-by-cycle properties of alu8_flagged, bound to every instance.
// Assumes the status layout and op codes of alu8_pkg.
module alu8_flagged_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] rhs_i,
    input logic              ien_we_i,
    input logic              ien_d_i,
    input logic [DATA_W-1:0] result_o,
    input logic [STAT_W-1:0] status_o
);

    logic direct_op;
    logic clears_co;
    logic no_flag_op;

    assign direct_op  = valid_i && (op_i != OP_CMP) && (op_i <= OP_SHR);
    assign clears_co  = valid_i && ((op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                                    (op_i == OP_COM) || (op_i == OP_SHL) || (op_i == OP_SHR));
    assign no_flag_op = op_i >= OP_CLR;

    AST_SIGN_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        direct_op |=> status_o[ST_SIGN] == ~$past(result_o[DATA_W-1])); // R5
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        direct_op |=> status_o[ST_ZERO] == ($past(result_o) == '0)); // R6
    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (!rst_n)
        clears_co |=> !status_o[ST_CARRY] && !status_o[ST_OVF]); // R3
    AST_CMP_PASSES_RHS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> result_o == rhs_i); // R2
    AST_CLR_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        no_flag_op |-> result_o == '0); // R7
    AST_CLR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        no_flag_op |=> $stable(status_o[ST_OVF:ST_SIGN])); // R7
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(status_o[ST_OVF:ST_SIGN])); // R8
    AST_IEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_we_i |=> $stable(status_o[ST_IEN])); // R9
    AST_IEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we_i |=> status_o[ST_IEN] == $past(ien_d_i)); // R9

endmodule

bind alu8_flagged alu8_flagged_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .rhs_i    (rhs_i),
    .ien_we_i (ien_we_i),
    .ien_d_i  (ien_d_i),
    .result_o (result_o),
    .status_o (status_o)
);

// File: tb/alu8_flagged_tb_top.sv
// Bench: directed corner cases plus seeded random operations, checked
// against a behavioural model written from the requirements.
module alu8_flagged_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] op_i = '0;
    logic       src_sel_i = 1'b0;
    logic [7:0] lhs_i = '0;
    logic [7:0] rhs_i = '0;
    logic       ien_we_i = 1'b0;
    logic       ien_d_i = 1'b0;
    logic [7:0] result_o;
    logic [4:0] status_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [4:0] exp_st = '0;

    always #(CLK_P/2) clk = ~clk;

    alu8_flagged dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .op_i      (op_i),
        .src_sel_i (src_sel_i),
        .lhs_i     (lhs_i),
        .rhs_i     (rhs_i),
        .ien_we_i  (ien_we_i),
        .ien_d_i   (ien_d_i),
        .result_o  (result_o),
        .status_o  (status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:                   return "R1 add";
            4'd1:                   return "R2 compare";
            4'd2, 4'd3, 4'd4:       return "R3 logic";
            4'd5, 4'd6, 4'd7,
            4'd8, 4'd9:             return "R4 unary";
            default:                return "R7 clear/unused";
        endcase
    endfunction

    function automatic logic [7:0] m_res(input logic [3:0] op, input logic [7:0] l,
                                         input logic [7:0] r, input logic sel);
        logic [7:0] s;
        s = sel ? r : l;
        case (op)
            4'd0: return l + r;
            4'd1: return r;
            4'd2: return l & r;
            4'd3: return l | r;
            4'd4: return l ^ r;
            4'd5: return ~s;
            4'd6: return s + 8'd1;
            4'd7: return s - 8'd1;
            4'd8: return s << 1;
            4'd9: return s >> 1;
            default: return 8'd0;
        endcase
    endfunction

    // Returns {ovf, zero, carry, sign}; unchanged for clear and unused codes.
    function automatic logic [3:0] m_flags(input logic [3:0] op, input logic [7:0] l,
                                           input logic [7:0] r, input logic sel,
                                           input logic [3:0] old);
        logic [8:0] wide;
        logic [7:0] v;
        logic [7:0] s;
        logic       c;
        logic       o;
        s = sel ? r : l;
        c = 1'b0;
        o = 1'b0;
        case (op)
            4'd0: begin
                wide = {1'b0, l} + {1'b0, r};
                v = wide[7:0];
                c = wide[8];
                o = (l[7] == r[7]) && (v[7] != l[7]);
            end
            4'd1: begin
                v = r - l;
                c = (r >= l);
                o = (r[7] != l[7]) && (v[7] != r[7]);
            end
            4'd6: begin v = s + 8'd1; c = (s == 8'hFF); o = (s == 8'h7F); end
            4'd7: begin v = s - 8'd1; c = (s != 8'h00); o = (s == 8'h80); end
            4'd2, 4'd3, 4'd4, 4'd5, 4'd8, 4'd9: v = m_res(op, l, r, sel);
            default: return old;
        endcase
        return {o, (v == 8'd0), c, ~v[7]};
    endfunction

    task automatic step(input logic [3:0] op, input logic [7:0] l, input logic [7:0] r,
                        input logic sel, input logic v, input logic we, input logic d);
        logic [4:0] nxt;
        @(negedge clk);
        op_i = op; lhs_i = l; rhs_i = r; src_sel_i = sel;
        valid_i = v; ien_we_i = we; ien_d_i = d;
        #1;
        check({tag_of(op), " result"}, 32'(result_o), 32'(m_res(op, l, r, sel)));
        nxt = exp_st;
        if (v) nxt[3:0] = m_flags(op, l, r, sel, exp_st[3:0]);
        if (we) nxt[4] = d;
        exp_st = nxt;
        @(posedge clk);
        #1;
        if (!v || op >= 4'd10) begin
            check(v ? "R7 flags held" : "R8 flags held when idle",
                  32'(status_o[3:0]), 32'(exp_st[3:0]));
        end else begin
            check("R5 sign", 32'(status_o[0]), 32'(exp_st[0]));
            check("R6 zero", 32'(status_o[2]), 32'(exp_st[2]));
            check({tag_of(op), " carry/ovf"}, 32'({status_o[3], status_o[1]}),
                  32'({exp_st[3], exp_st[1]}));
        end
        check("R9 interrupt enable", 32'(status_o[4]), 32'(exp_st[4]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd51723;
        void'($urandom(seed));
        // Reset with a strobe asserted: reset wins.
        ien_we_i = 1'b1; ien_d_i = 1'b1; valid_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset status", 32'(status_o), 32'd0);
        @(negedge clk);
        ien_we_i = 1'b0; valid_i = 1'b0;
        rst_n = 1'b1;
        exp_st = '0;

        // R1 add corners.
        step(4'd0, 8'h7F, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd0, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0);
        // R2 compare: equal, right below left, signed overflow.
        step(4'd1, 8'h42, 8'h42, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd1, 8'h10, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd1, 8'h01, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0);
        // R3 logic clears carry left set by a prior add.
        step(4'd0, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd2, 8'hF0, 8'h0F, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd4, 8'hAA, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
        // R4 unary corners, both sources.
        step(4'd6, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd6, 8'h00, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b0);
        step(4'd7, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd7, 8'h33, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        step(4'd8, 8'h81, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd9, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
        step(4'd5, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        // R7 clear and unused codes keep flags; R8 idle keeps flags.
        step(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd10, 8'h12, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd13, 8'h12, 8'h34, 1'b1, 1'b1, 1'b0, 1'b0);
        step(4'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        // R9 enable load, then operations leave it alone.
        step(4'd0, 8'h01, 8'h02, 1'b0, 1'b1, 1'b1, 1'b1);
        step(4'd10, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd1, 8'h05, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0);
        step(4'd2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);

        // Seeded random mix.
        for (int i = 0; i < 400; i++) begin
            step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), 1'($urandom));
        end
        finish_run();
    end

endmodule